// File: doc/BRIEF.md
# Statistics Counter Bank with Overflow-Warning Interrupt

This block keeps a bank of wide event counters, one per incoming strobe, and raises a level interrupt whenever any counter reaches the upper half of its range (its most significant bit is set). The interrupt warns software that a counter is getting close to saturation, so that software reads it out before information is lost.

Software reaches the bank through a simple register port. Reading a counter address returns its value. Writing to a counter address subtracts the written value from it instead of loading it. Software acknowledges the interrupt by subtracting what it has accounted for. The interrupt stays asserted until no counter has its top bit set. A control register holds the enable bit that gates the interrupt pin. A status register shows the ungated condition.

Top module: `stat_irq_bank`

## Requirements
- R1: Reset (rst_ni low, asynchronous) clears every counter, clears the enable bit and holds irq_o low.
- R2: A high evt_i[k] at a clock edge increments counter k by one, visible at the next read. Counter k reads at address k. A counter with no strobe and no write keeps its value.
- R3: A counter at all ones stays at all ones when strobed again. It never wraps to zero.
- R4: A write to address k (k < NUM_CNT) subtracts reg_wdata_i from counter k instead of loading it.
- R5: When a strobe and a decrement write hit the same counter in one cycle, the result is value minus write data plus one.
- R6: A decrement that would take a counter below zero leaves it at zero.
- R7: Bit 0 of the status register (address NUM_CNT+1) reads 1 exactly when some counter has its MSB set (value >= 0x8000_0000 at the default 32-bit width), whatever the enable bit.
- R8: Bit 0 of the control register (address NUM_CNT) is the read/write interrupt enable. irq_o is high only when that bit is 1 and the status bit is 1.
- R9: irq_o stays asserted while any counter's MSB is set. It drops only after decrement writes have cleared the MSB of the last such counter.
- R10: Writes to the status address have no effect. Reads of unmapped addresses return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | NUM_CNT | Increment strobes, one per counter |
| reg_we_i | input | 1 | Register write enable |
| reg_addr_i | input | ADDR_W | Register address for both reads and writes |
| reg_wdata_i | input | CNT_W | Write data: the decrement amount for a counter, bit 0 for control |
| reg_rdata_o | output | CNT_W | Combinational read data for reg_addr_i |
| irq_o | output | 1 | Level interrupt, gated by the enable bit |

## Verification
The condition that is hardest to reach from the ports is a counter with its top bit set. Decrements floor at zero, so the only way up is one strobe per cycle, and a 32-bit counter would need 2^31 cycles. The bench therefore builds the bank with an 8-bit counter width. A strobe held for 128 cycles then sets the MSB, and 300 cycles drive the counter into saturation. This lets the bench exercise the interrupt, the acknowledge by decrement, and the all-ones corner under the same logic that runs at full width.

// File: rtl/stat_irq_pkg.sv
package stat_irq_pkg;
  typedef enum logic [1:0] {
    SEL_CNT  = 2'd0,
    SEL_CTRL = 2'd1,
    SEL_STAT = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/stat_addr_dec.sv
module stat_addr_dec
  import stat_irq_pkg::*;
#(
  parameter int NUM_CNT = 8,
  parameter int ADDR_W  = 4,
  localparam int IDX_W  = (NUM_CNT > 1) ? $clog2(NUM_CNT) : 1
) (
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               we_i,
  output reg_sel_e           sel_o,
  output logic [IDX_W-1:0]   idx_o,
  output logic [NUM_CNT-1:0] dec_we_o,
  output logic               ctrl_we_o
);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(NUM_CNT);
  localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(NUM_CNT + 1);

  always_comb begin
    if (addr_i < CTRL_ADDR)       sel_o = SEL_CNT;
    else if (addr_i == CTRL_ADDR) sel_o = SEL_CTRL;
    else if (addr_i == STAT_ADDR) sel_o = SEL_STAT;
    else                          sel_o = SEL_NONE;
  end

  assign idx_o     = addr_i[IDX_W-1:0];
  assign ctrl_we_o = we_i && (sel_o == SEL_CTRL);

  for (genvar k = 0; k < NUM_CNT; k++) begin : g_dec
    assign dec_we_o[k] = we_i && (sel_o == SEL_CNT) && (idx_o == IDX_W'(k));
  end
endmodule

// File: rtl/stat_counter.sv
module stat_counter #(
  parameter int CNT_W = 32,
  localparam int EXT_W = CNT_W + 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             dec_i,
  input  logic [CNT_W-1:0] dec_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             msb_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [EXT_W-1:0] sum;

  // two guard bits: top = borrow, next = carry past all ones
  always_comb begin
    sum = {2'b00, cnt_q} + {{(EXT_W-1){1'b0}}, inc_i}
        - (dec_i ? {2'b00, dec_val_i} : '0);
    if (sum[EXT_W-1])   cnt_d = '0;
    else if (sum[CNT_W]) cnt_d = CNT_MAX;
    else                 cnt_d = sum[CNT_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
  assign msb_o = cnt_q[CNT_W-1];

  AST_INC_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !dec_i && cnt_q != CNT_MAX) |=> cnt_q == $past(cnt_q) + 1'b1); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inc_i && !dec_i) |=> $stable(cnt_q)); // R2
  AST_SAT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !dec_i && cnt_q == CNT_MAX) |=> cnt_q == CNT_MAX); // R3
  AST_DEC_SUB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_i && !inc_i && dec_val_i <= cnt_q) |=> cnt_q == $past(cnt_q) - $past(dec_val_i)); // R4
  AST_DEC_FLOOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_i && !inc_i && dec_val_i > cnt_q) |=> cnt_q == '0); // R6
endmodule

// File: rtl/stat_irq_ctrl.sv
module stat_irq_ctrl #(
  parameter int NUM_CNT = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ctrl_we_i,
  input  logic               ctrl_wbit_i,
  input  logic [NUM_CNT-1:0] msb_i,
  output logic               en_o,
  output logic               raw_o,
  output logic               irq_o
);
  logic en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        en_q <= 1'b0;
    else if (ctrl_we_i) en_q <= ctrl_wbit_i;
  end

  assign en_o  = en_q;
  assign raw_o = |msb_i;
  assign irq_o = en_q & raw_o;

  AST_EN_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_we_i |=> en_q == $past(ctrl_wbit_i)); // R8
  AST_EN_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_we_i |=> $stable(en_q)); // R8
endmodule

// File: rtl/stat_irq_bank.sv
module stat_irq_bank
  import stat_irq_pkg::*;
#(
  parameter int NUM_CNT = 8,
  parameter int CNT_W   = 32,
  parameter int ADDR_W  = 4,
  localparam int IDX_W  = (NUM_CNT > 1) ? $clog2(NUM_CNT) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_CNT-1:0] evt_i,
  input  logic               reg_we_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [CNT_W-1:0]   reg_wdata_i,
  output logic [CNT_W-1:0]   reg_rdata_o,
  output logic               irq_o
);
  reg_sel_e           sel;
  logic [IDX_W-1:0]   idx;
  logic [NUM_CNT-1:0] dec_we;
  logic               ctrl_we;
  logic [NUM_CNT-1:0] msb;
  logic [CNT_W-1:0]   cnt [NUM_CNT];
  logic               en, raw;

  stat_addr_dec #(.NUM_CNT(NUM_CNT), .ADDR_W(ADDR_W)) u_dec (
    .addr_i   (reg_addr_i),
    .we_i     (reg_we_i),
    .sel_o    (sel),
    .idx_o    (idx),
    .dec_we_o (dec_we),
    .ctrl_we_o(ctrl_we)
  );

  for (genvar k = 0; k < NUM_CNT; k++) begin : g_cnt
    stat_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .inc_i    (evt_i[k]),
      .dec_i    (dec_we[k]),
      .dec_val_i(reg_wdata_i),
      .cnt_o    (cnt[k]),
      .msb_o    (msb[k])
    );
  end

  stat_irq_ctrl #(.NUM_CNT(NUM_CNT)) u_irq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ctrl_we_i  (ctrl_we),
    .ctrl_wbit_i(reg_wdata_i[0]),
    .msb_i      (msb),
    .en_o       (en),
    .raw_o      (raw),
    .irq_o      (irq_o)
  );

  always_comb begin
    unique case (sel)
      SEL_CNT:  reg_rdata_o = cnt[idx];
      SEL_CTRL: reg_rdata_o = {{(CNT_W-1){1'b0}}, en};
      SEL_STAT: reg_rdata_o = {{(CNT_W-1){1'b0}}, raw};
      default:  reg_rdata_o = '0;
    endcase
  end

  // MSB can only appear through strobes and vanish through decrement writes
  AST_RAW_RISE_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(raw) |-> $past(|evt_i)); // R7
  AST_RAW_FALL_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(raw) |-> $past(|dec_we)); // R9
endmodule

// File: tb/tb_stat_irq_bank.sv
`timescale 1ns/1ps
module tb_stat_irq_bank;
  localparam int NC = 8;
  localparam int W  = 8;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NC-1:0] evt = '0;
  logic          we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [W-1:0]  wdata = '0;
  logic [W-1:0]  rdata;
  logic          irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  stat_irq_bank #(.NUM_CNT(NC), .CNT_W(W), .ADDR_W(AW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .reg_we_i(we),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
  );

  typedef struct packed {
    logic [7:0] evt;
    logic       we;
    logic [3:0] addr;
    logic [7:0] wdata;
    logic [3:0] caddr;
    logic [7:0] exp;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{8'h01, 1'b0, 4'd0, 8'd0,   4'd0,  8'd1, 4'd2},  // R2
    '{8'h03, 1'b0, 4'd0, 8'd0,   4'd0,  8'd2, 4'd2},  // R2
    '{8'h00, 1'b0, 4'd0, 8'd0,   4'd1,  8'd1, 4'd2},  // R2 hold
    '{8'h00, 1'b1, 4'd0, 8'd1,   4'd0,  8'd1, 4'd4},  // R4
    '{8'h01, 1'b1, 4'd0, 8'd1,   4'd0,  8'd1, 4'd5},  // R5
    '{8'h02, 1'b1, 4'd1, 8'd5,   4'd1,  8'd0, 4'd6},  // R6
    '{8'h00, 1'b1, 4'd0, 8'd200, 4'd0,  8'd0, 4'd6},  // R6
    '{8'h80, 1'b0, 4'd0, 8'd0,   4'd7,  8'd1, 4'd2},  // R2
    '{8'h80, 1'b1, 4'd7, 8'd0,   4'd7,  8'd2, 4'd5},  // R5
    '{8'h40, 1'b1, 4'd6, 8'd1,   4'd6,  8'd0, 4'd5},  // R5
    '{8'h00, 1'b1, 4'd9, 8'hFF,  4'd9,  8'd0, 4'd10}, // R10
    '{8'h00, 1'b0, 4'd0, 8'd0,   4'd15, 8'd0, 4'd10}, // R10
    '{8'h00, 1'b1, 4'd8, 8'd1,   4'd8,  8'd1, 4'd8},  // R8
    '{8'h00, 1'b1, 4'd8, 8'd0,   4'd8,  8'd0, 4'd8},  // R8
    '{8'hFF, 1'b0, 4'd0, 8'd0,   4'd5,  8'd1, 4'd2}   // R2
  };

  task automatic check(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [AW-1:0] a, output int v);
    @(negedge clk);
    evt = '0; we = 1'b0; addr = a;
    #1 v = int'(rdata);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [W-1:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic pulse(input int k, input int n);
    @(negedge clk);
    evt = '0;
    evt[k] = 1'b1;
    repeat (n) @(posedge clk);
    @(negedge clk);
    evt = '0;
  endtask

  initial begin
    int v;
    #20;
    // R1: reset state
    for (int k = 0; k < NC; k++) begin
      rd(AW'(k), v);
      check(v, 0, "R1 counter at reset");
    end
    rd(4'd8, v);
    check(v, 0, "R1 enable at reset");
    check(int'(irq), 0, "R1 irq at reset");
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      evt = VECS[i].evt; we = VECS[i].we; addr = VECS[i].addr; wdata = VECS[i].wdata;
      @(posedge clk);
      rd(VECS[i].caddr, v);
      check(v, int'(VECS[i].exp), $sformatf("R%0d vector %0d", VECS[i].req, i));
    end

    // R1: mid-run reset
    @(negedge clk);
    wr(4'd8, 8'd1);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    rd(4'd7, v);
    check(v, 0, "R1 counter after reset");
    rd(4'd8, v);
    check(v, 0, "R1 enable after reset");
    @(negedge clk);
    rst_n = 1'b1;

    // R7: MSB sets status bit, gated pin stays low
    pulse(2, 127);
    rd(4'd2, v);
    check(v, 127, "R2 long strobe");
    rd(4'd9, v);
    check(v, 0, "R7 status below MSB");
    pulse(2, 1);
    rd(4'd9, v);
    check(v, 1, "R7 status at MSB");
    check(int'(irq), 0, "R8 irq gated off");
    wr(4'd8, 8'd1);
    #1 check(int'(irq), 1, "R8 irq enabled");
    pulse(3, 128);
    // R9: stays while any MSB set
    wr(4'd2, 8'd1);
    rd(4'd2, v);
    check(v, 127, "R4 decrement clears MSB");
    check(int'(irq), 1, "R9 irq held by other counter");
    wr(4'd3, 8'd1);
    rd(4'd9, v);
    check(v, 0, "R9 status cleared");
    check(int'(irq), 0, "R9 irq cleared");

    // R3: saturation
    pulse(4, 300);
    rd(4'd4, v);
    check(v, 255, "R3 saturates");
    check(int'(irq), 1, "R9 irq from saturated counter");
    @(negedge clk);
    evt[4] = 1'b1; we = 1'b1; addr = 4'd4; wdata = 8'd0;
    @(posedge clk);
    rd(4'd4, v);
    check(v, 255, "R3 saturated with zero decrement");
    wr(4'd4, 8'd255);
    rd(4'd4, v);
    check(v, 0, "R4 full decrement");
    check(int'(irq), 0, "R9 irq after full decrement");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule